// File: doc/BRIEF.md
# Delay-Tap Eye-Centre Calibration Controller

This block finds a good sampling point for each lane of a multi-lane serial receiver. It steps the input-delay tap of every lane through all available offsets in increasing order. After each step it waits a programmable settle time. It then counts the error strobes from each lane's pseudo-random pattern checker over a programmable window. An offset where the window holds no error is clean, and any other offset is bad.

Each lane is judged on its own. The chosen tap is the middle of that lane's first clean run of offsets. The opening edge of the run is its first clean offset. The closing edge is the first bad offset after it, or one past the last offset if no bad offset follows. A lane with no clean offset is flagged as failed and parked at tap 0. A start pulse launches the sweep, and a one-cycle done pulse reports the final placement.

Top module: `eye_cal_ctrl`

## Requirements
- R1: After a start pulse, every lane's tap output steps through the offsets 0 to NUM_TAPS-1 (0 to 30 by default) in increasing order, one offset per measurement.
- R2: Error strobes in the first settle_cycles_i cycles after a tap update are ignored (a value of 0 acts as 1). Strobes in the following window_cycles_i cycles are counted, and the offset is bad if any strobe was counted.
- R3: A lane that is clean at offset 0 gets the first bad offset shifted right by one as its final tap (25 gives 12, 22 gives 11).
- R4: A lane that is bad at offset 0 gets the sum of its first clean offset and the next bad offset, shifted right by one (4 and 20 give 12).
- R5: When a lane's clean run reaches the last offset, the closing edge is NUM_TAPS (31), so a lane clean everywhere is given tap 15.
- R6: A lane bad at every offset has its bit of fail_o set and its final tap at 0. fail_o holds until the next accepted start.
- R7: Lanes are evaluated independently, and one lane's errors never change another lane's result.
- R8: A lane's tap_ld_o bit is high for exactly those cycles in which that lane's tap output differs from its value in the previous cycle.
- R9: done_o is high for exactly one cycle per sweep. That is the cycle in which the final taps first appear.
- R10: A start pulse while a sweep is running has no effect. The sweep continues in order and ends with a single done pulse.
- R11: After reset, all taps are 0, and tap_ld_o, fail_o and done_o are low.
- R12: Only the first clean run counts. Clean offsets after the closing edge do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; taken only when idle |
| settle_cycles_i | input | SET_W | Cycles ignored after each tap update |
| window_cycles_i | input | WIN_W | Cycles of error counting per offset |
| lane_err_i | input | NUM_LANES | Per-lane error strobe from the pattern checker |
| tap_o | output | NUM_LANES*TAP_W | Per-lane tap value, lane 0 in the low bits |
| tap_ld_o | output | NUM_LANES | Per-lane tap load strobe |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | NUM_LANES | Per-lane no-clean-offset flag |

## Verification
The bench models each lane's eye as a 31-bit mask of bad offsets and forces error strobes for the settle period after every tap load. Any counting during settle therefore spoils the result. Several mask shapes are used. An eye clean from the low end separates the halving rule from the averaging rule. An eye with errors at the low end exercises averaging. A fully clean eye checks the closing edge at 31, and a fully bad eye checks the fail path. Eyes with a second clean run show that only the first run is taken. Mixing these shapes across lanes in one sweep shows that the lanes are independent. A start pulse injected mid-sweep must not restart the tap sequence.

// File: rtl/eye_cal_pkg.sv
package eye_cal_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_COUNT,
    ST_EVAL,
    ST_PLACE,
    ST_DONE
  } cal_state_e;
endpackage

// File: rtl/eye_sweep_seq.sv
module eye_sweep_seq
  import eye_cal_pkg::*;
#(
  parameter int NUM_TAPS = 31,
  parameter int TAP_W    = $clog2(NUM_TAPS),
  parameter int SET_W    = 8,
  parameter int WIN_W    = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [SET_W-1:0] settle_cycles_i,
  input  logic [WIN_W-1:0] window_cycles_i,
  output logic             start_clr_o,
  output logic             sweep_wr_o,
  output logic [TAP_W-1:0] sweep_tap_o,
  output logic [TAP_W-1:0] cur_tap_o,
  output logic             count_en_o,
  output logic             eval_o,
  output logic             place_o,
  output logic             done_o
);
  localparam int CNT_W = (SET_W > WIN_W) ? SET_W : WIN_W;
  localparam logic [TAP_W-1:0] LAST_TAP = TAP_W'(NUM_TAPS - 1);

  cal_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [TAP_W-1:0] tap_sel_q;
  logic [CNT_W:0]   cnt_nxt;
  logic             settle_end, win_end, last_tap;

  assign cnt_nxt    = {1'b0, cnt_q} + 1'b1;
  assign settle_end = cnt_nxt >= (CNT_W+1)'(settle_cycles_i);
  assign win_end    = cnt_nxt >= (CNT_W+1)'(window_cycles_i);
  assign last_tap   = tap_sel_q == LAST_TAP;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      tap_sel_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q   <= ST_SETTLE;
          tap_sel_q <= '0;
          cnt_q     <= '0;
        end
        ST_SETTLE: if (settle_end) begin
          state_q <= ST_COUNT;
          cnt_q   <= '0;
        end else cnt_q <= cnt_nxt[CNT_W-1:0];
        ST_COUNT: if (win_end) begin
          state_q <= ST_EVAL;
          cnt_q   <= '0;
        end else cnt_q <= cnt_nxt[CNT_W-1:0];
        ST_EVAL: if (last_tap) state_q <= ST_PLACE;
        else begin
          state_q   <= ST_SETTLE;
          tap_sel_q <= tap_sel_q + 1'b1;
          cnt_q     <= '0;
        end
        ST_PLACE: state_q <= ST_DONE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    start_clr_o = (state_q == ST_IDLE) && start_i;
    sweep_wr_o  = start_clr_o || ((state_q == ST_EVAL) && !last_tap);
    sweep_tap_o = start_clr_o ? '0 : tap_sel_q + 1'b1;
    cur_tap_o   = tap_sel_q;
    count_en_o  = state_q == ST_COUNT;
    eval_o      = state_q == ST_EVAL;
    place_o     = state_q == ST_PLACE;
    done_o      = state_q == ST_DONE;
  end

  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DONE) |=> (state_q != ST_DONE));
  a_r10_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && (state_q == ST_SETTLE || state_q == ST_COUNT)) |=> $stable(tap_sel_q));
  a_r1_sweep_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_EVAL && !last_tap) |=> (tap_sel_q == $past(tap_sel_q) + 1'b1));
endmodule

// File: rtl/eye_lane_eval.sv
module eye_lane_eval #(
  parameter int NUM_TAPS = 31,
  parameter int TAP_W    = $clog2(NUM_TAPS),
  parameter int ERR_W    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_clr_i,
  input  logic             sweep_wr_i,
  input  logic [TAP_W-1:0] sweep_tap_i,
  input  logic [TAP_W-1:0] cur_tap_i,
  input  logic             count_en_i,
  input  logic             err_i,
  input  logic             eval_i,
  input  logic             place_i,
  output logic [TAP_W-1:0] tap_o,
  output logic             tap_ld_o,
  output logic             fail_o
);
  localparam int EDGE_W = $clog2(NUM_TAPS + 1);
  localparam logic [EDGE_W-1:0] END_EDGE = EDGE_W'(NUM_TAPS);

  logic [ERR_W-1:0]  err_cnt_q;
  logic              open_q, close_q, fail_q, ld_q;
  logic [EDGE_W-1:0] open_tap_q, close_tap_q;
  logic [TAP_W-1:0]  tap_q, tap_nxt, mid_tap;
  logic [EDGE_W:0]   edge_sum;
  logic              clean, tap_wr;

  assign clean    = err_cnt_q == '0;
  assign edge_sum = {1'b0, open_tap_q} + {1'b0, (close_q ? close_tap_q : END_EDGE)};
  assign mid_tap  = TAP_W'(edge_sum >> 1);
  assign tap_wr   = sweep_wr_i || place_i;

  always_comb begin
    tap_nxt = tap_q;
    if (sweep_wr_i)   tap_nxt = sweep_tap_i;
    else if (place_i) tap_nxt = open_q ? mid_tap : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_cnt_q   <= '0;
      open_q      <= 1'b0;
      close_q     <= 1'b0;
      open_tap_q  <= '0;
      close_tap_q <= '0;
      fail_q      <= 1'b0;
      tap_q       <= '0;
      ld_q        <= 1'b0;
    end else begin
      ld_q  <= tap_wr && (tap_nxt != tap_q);
      tap_q <= tap_nxt;
      if (sweep_wr_i) err_cnt_q <= '0;
      else if (count_en_i && err_i && !(&err_cnt_q)) err_cnt_q <= err_cnt_q + 1'b1;
      if (start_clr_i) begin
        open_q  <= 1'b0;
        close_q <= 1'b0;
        fail_q  <= 1'b0;
      end else if (eval_i) begin
        if (!open_q && clean) begin
          open_q     <= 1'b1;
          open_tap_q <= EDGE_W'(cur_tap_i);
        end else if (open_q && !close_q && !clean) begin
          close_q     <= 1'b1;
          close_tap_q <= EDGE_W'(cur_tap_i);
        end
      end else if (place_i) fail_q <= !open_q;
    end
  end

  assign tap_o    = tap_q;
  assign tap_ld_o = ld_q;
  assign fail_o   = fail_q;

  a_r8_ld_on_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tap_q != $past(tap_q)) |-> ld_q);
  a_r6_fail_tap_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_q |-> (tap_q == '0));
  a_r1_tap_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tap_q < TAP_W'(NUM_TAPS));
  a_r2_no_count_outside: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!count_en_i && !sweep_wr_i) |=> $stable(err_cnt_q));
endmodule

// File: rtl/eye_cal_ctrl.sv
module eye_cal_ctrl #(
  parameter int NUM_LANES = 3,
  parameter int NUM_TAPS  = 31,
  parameter int TAP_W     = $clog2(NUM_TAPS),
  parameter int SET_W     = 8,
  parameter int WIN_W     = 12,
  parameter int ERR_W     = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic [SET_W-1:0]           settle_cycles_i,
  input  logic [WIN_W-1:0]           window_cycles_i,
  input  logic [NUM_LANES-1:0]       lane_err_i,
  output logic [NUM_LANES*TAP_W-1:0] tap_o,
  output logic [NUM_LANES-1:0]       tap_ld_o,
  output logic                       done_o,
  output logic [NUM_LANES-1:0]       fail_o
);
  logic             start_clr, sweep_wr, count_en, eval, place;
  logic [TAP_W-1:0] sweep_tap, cur_tap;

  eye_sweep_seq #(
    .NUM_TAPS(NUM_TAPS), .TAP_W(TAP_W), .SET_W(SET_W), .WIN_W(WIN_W)
  ) u_seq (
    .clk_i, .rst_ni, .start_i, .settle_cycles_i, .window_cycles_i,
    .start_clr_o(start_clr), .sweep_wr_o(sweep_wr), .sweep_tap_o(sweep_tap),
    .cur_tap_o(cur_tap), .count_en_o(count_en), .eval_o(eval),
    .place_o(place), .done_o(done_o)
  );

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    eye_lane_eval #(
      .NUM_TAPS(NUM_TAPS), .TAP_W(TAP_W), .ERR_W(ERR_W)
    ) u_lane (
      .clk_i, .rst_ni,
      .start_clr_i(start_clr), .sweep_wr_i(sweep_wr), .sweep_tap_i(sweep_tap),
      .cur_tap_i(cur_tap), .count_en_i(count_en), .err_i(lane_err_i[l]),
      .eval_i(eval), .place_i(place),
      .tap_o(tap_o[l*TAP_W +: TAP_W]), .tap_ld_o(tap_ld_o[l]), .fail_o(fail_o[l])
    );
  end

  a_r9_final_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(place));
endmodule

// File: tb/eye_cal_ctrl_tb.sv
module eye_cal_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 3;
  localparam int NT = 31;
  localparam int TW = 5;

  logic          clk = 0, rst_n = 0, start = 0;
  logic [7:0]    settle = 8'd4;
  logic [11:0]   window = 12'd6;
  logic [NL-1:0] lane_err;
  logic [NL*TW-1:0] tap;
  logic [NL-1:0] tap_ld, fail;
  logic          done;

  int checks = 0, errors = 0;
  logic [NT-1:0] bad_mask [NL];
  int glitch [NL];

  always #(CLK_PERIOD/2) clk = ~clk;

  eye_cal_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .settle_cycles_i(settle), .window_cycles_i(window),
    .lane_err_i(lane_err), .tap_o(tap), .tap_ld_o(tap_ld),
    .done_o(done), .fail_o(fail)
  );

  // eye model: errors forced during settle after a load, else per-offset mask
  always @(negedge clk) begin
    for (int l = 0; l < NL; l++) begin
      if (tap_ld[l]) glitch[l] = int'(settle);
      lane_err[l] <= (glitch[l] > 0) || bad_mask[l][tap[l*TW +: TW]];
      if (glitch[l] > 0) glitch[l] = glitch[l] - 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void expect_tap(input logic [NT-1:0] m, output int t, output bit f);
    int open_e = -1, close_e = NT;
    bit closed = 0;
    for (int i = 0; i < NT; i++) begin
      if (open_e < 0 && !m[i]) open_e = i;
      else if (open_e >= 0 && !closed && m[i]) begin close_e = i; closed = 1; end
    end
    f = open_e < 0;
    t = f ? 0 : (open_e + close_e) / 2;
  endfunction

  task automatic run_sweep(input string name, input int inject_at);
    int nxt [NL];
    int last [NL];
    int prev [NL];
    int dones = 0, cyc = 0, et;
    bit ef, order_ok = 1, ld_ok = 1, seen_done = 0;
    for (int l = 0; l < NL; l++) begin
      nxt[l] = 0; last[l] = -1; prev[l] = int'(tap[l*TW +: TW]);
    end
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    while (!seen_done && cyc < 5000) begin
      for (int l = 0; l < NL; l++) begin
        int cur = int'(tap[l*TW +: TW]);
        if ((cur != prev[l]) != tap_ld[l]) ld_ok = 0;
        if (tap_ld[l] && !done) begin
          if (!(cur == nxt[l] || (nxt[l] == 0 && cur == 1))) order_ok = 0;
          nxt[l] = cur + 1; last[l] = cur;
        end
        prev[l] = cur;
      end
      if (done) begin
        dones++; seen_done = 1;
        for (int l = 0; l < NL; l++) begin
          expect_tap(bad_mask[l], et, ef);
          chk(int'(tap[l*TW +: TW]) == et, $sformatf("R3/R4/R5/R7/R12 %s lane%0d tap", name, l),
              int'(tap[l*TW +: TW]), et);
          chk(fail[l] == ef, $sformatf("R6 %s lane%0d fail", name, l), int'(fail[l]), int'(ef));
        end
      end else begin
        cyc++;
        if (cyc == inject_at) start = 1;
        if (cyc == inject_at + 1) start = 0;
        @(negedge clk);
      end
    end
    chk(seen_done, {"watchdog ", name}, cyc, 0);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (done) dones++;
      for (int l = 0; l < NL; l++)
        if (tap_ld[l] != (int'(tap[l*TW +: TW]) != prev[l])) ld_ok = 0;
      for (int l = 0; l < NL; l++) prev[l] = int'(tap[l*TW +: TW]);
    end
    chk(dones == 1, {"R9 single done ", name}, dones, 1);
    chk(order_ok, {"R1/R10 sweep order ", name}, int'(order_ok), 1);
    for (int l = 0; l < NL; l++)
      chk(last[l] == NT - 1, {"R1 last sweep offset ", name}, last[l], NT - 1);
    chk(ld_ok, {"R8 load strobe on change ", name}, int'(ld_ok), 1);
  endtask

  // R3, R7: eyes clean from offset 0 closing at different offsets
  task automatic t_clean_low();
    bad_mask[0] = ~((31'h1 << 25) - 1);
    bad_mask[1] = ~((31'h1 << 22) - 1);
    bad_mask[2] = ~((31'h1 << 24) - 1);
    run_sweep("clean_low", 0);
  endtask

  // R4, R6, R2: errors at low end, averaging, all-bad lane
  task automatic t_low_errors();
    bad_mask[0] = ((31'h1 << 4) - 1) | ~((31'h1 << 20) - 1);
    bad_mask[1] = (31'h1 << 7) - 1;
    bad_mask[2] = '1;
    run_sweep("low_errors", 0);
  endtask

  // R5, R12: fully clean lane, second clean runs ignored
  task automatic t_multi_run();
    settle = 8'd3;
    window = 12'd9;
    bad_mask[0] = '0;
    bad_mask[1] = 31'h7C00;                    // bad 10..14
    bad_mask[2] = 31'h3FFFFFF9 & ~31'h6;       // bad 0 and 3..29
    run_sweep("multi_run", 0);
  endtask

  // R10: start pulse mid-sweep ignored
  task automatic t_restart();
    settle = 8'd4;
    window = 12'd6;
    bad_mask[0] = ~((31'h1 << 18) - 1);
    bad_mask[1] = (31'h1 << 2) - 1;
    bad_mask[2] = 31'h1 << 9;
    run_sweep("restart", 120);
  endtask

  initial begin
    for (int l = 0; l < NL; l++) begin bad_mask[l] = '0; glitch[l] = 0; end
    lane_err = '0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(tap == '0, "R11 reset tap", int'(tap), 0);
    chk(tap_ld == '0 && fail == '0, "R11 reset strobes/fail", int'({tap_ld, fail}), 0);
    chk(!done, "R11 reset done", int'(done), 0);
    rst_n = 1;
    @(negedge clk);
    t_clean_low();
    t_low_errors();
    t_multi_run();
    t_restart();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule